// File: doc/BRIEF.md
# Dual-Knee Exposure Time Scheduler

This block times the integration period of a wide-dynamic-range pixel exposure that has up to three slopes. A total integration length in rows is split into three segments. The second and third segments are power-of-two fractions of the total. The first segment is whatever remains. A row counter advances on a row-tick input. It raises a one-cycle strobe at each knee point, where the pixel array must change its saturation control level, and a final strobe when the full integration length has elapsed.

Configuration comes from a register file elsewhere and may change at any time. The block samples it only on a frame-start pulse, so a value written in the middle of a frame applies from the next frame. Two mode bits change the schedule. Auto-adjust turns the ratio-based knees on or off. Single-knee keeps the first knee and drops the second.

Top module: `wdr_knee_sched`

## Requirements
- R1: After reset, `knee1_o`, `knee2_o`, `done_o` and `active_o` are 0, and row ticks received before any frame start produce no strobe.
- R2: A `frame_start_i` pulse latches the configuration, clears the row count and sets `active_o` from the next cycle, with every strobe at 0 in that cycle.
- R3: With auto-adjust=1 and single-knee=0, `seg2 = total >> ratio2` and `seg3 = total >> ratio3`. When `seg2 + seg3 < total`, `seg1 = total - seg2 - seg3`, and `knee1_o` pulses in the cycle after the tick that brings the row count to `seg1`.
- R4: In double-knee mode, `knee2_o` pulses in the cycle after the tick that brings the row count to `seg1 + seg2`, provided that value is at most `total`.
- R5: `done_o` pulses in the cycle after the tick that brings the row count to `total`. `active_o` falls in the same cycle, and later ticks produce no strobe until the next frame start.
- R6: With single-knee=1 and auto-adjust=1, `seg3` is 0, `knee2_o` never pulses and `seg1 = total - seg2`.
- R7: With auto-adjust=0, neither knee strobe pulses, and `done_o` still pulses after `total` ticks.
- R8: A segment whose shifted length is 0 suppresses its knee strobe: `knee1_o` needs `seg2 > 0` and `knee2_o` needs `seg3 > 0`.
- R9: When `seg2 + seg3 >= total`, `seg1` is clamped to 1 row. The knee positions follow from that value, and the frame still completes with `done_o`.
- R10: Configuration inputs that change after the frame start have no effect on the current frame's strobes.
- R11: A row tick in the same cycle as `frame_start_i` is not counted. The frame restarts from row 0 with the newly latched configuration.
- R12: Each strobe is one cycle wide, and no strobe pulses in a cycle that does not follow a counted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start_i | input | 1 | Frame-start pulse; latches config and restarts the count |
| row_tick_i | input | 1 | One-cycle pulse per elapsed row |
| cfg_total_i | input | 15 | Total integration length in rows |
| cfg_ratio2_i | input | 4 | Shift amount for the second segment |
| cfg_ratio3_i | input | 4 | Shift amount for the third segment |
| cfg_auto_i | input | 1 | 1 enables ratio-based knees |
| cfg_single_i | input | 1 | 1 selects single-knee mode |
| knee1_o | output | 1 | Strobe at the end of segment 1 |
| knee2_o | output | 1 | Strobe at the end of segment 2 |
| done_o | output | 1 | Strobe when integration is complete |
| active_o | output | 1 | High while a frame's integration is counting |

## Verification
Two pairs of events can land in the same cycle.

- **A knee and the done strobe.** This happens in the clamped case, for example a total of 1 or shift amounts of 1 and 1. The bench sweeps every small total against every shift pair in all four mode combinations, so these coincidences are reached. Each tick is compared with positions computed arithmetically, so both strobes must be present together.
- **A frame start and a row tick.** The bench raises both in one cycle partway through a running frame. It then expects no strobe in that cycle and a full new schedule counted from zero under the new configuration.

// File: rtl/wdr_knee_pkg.sv
// Package: shared widths and reset defaults for the exposure knee scheduler.
// Assumes the total width fits 15 bits and the ratio fields fit 4 bits.
package wdr_knee_pkg;
    localparam int TOTAL_W_DEF = 15;
    localparam int RATIO_W_DEF = 4;
    localparam int TOTAL_RST   = 480;
    localparam int RATIO2_RST  = 4;
    localparam int RATIO3_RST  = 6;
    localparam bit AUTO_RST    = 1'b1;
    localparam bit SINGLE_RST  = 1'b0;
endpackage

// File: rtl/wdr_cfg_hold.sv
// Module: holds the exposure configuration for the current frame.
// Captures every configuration input on the frame-start pulse only, so
// mid-frame writes wait for the next frame. Reset loads the defaults.
module wdr_cfg_hold
    import wdr_knee_pkg::*;
#(
    parameter int TOTAL_W = TOTAL_W_DEF,
    parameter int RATIO_W = RATIO_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_i,
    input  logic [TOTAL_W-1:0] total_i,
    input  logic [RATIO_W-1:0] ratio2_i,
    input  logic [RATIO_W-1:0] ratio3_i,
    input  logic               auto_i,
    input  logic               single_i,
    output logic [TOTAL_W-1:0] total_o,
    output logic [RATIO_W-1:0] ratio2_o,
    output logic [RATIO_W-1:0] ratio3_o,
    output logic               auto_o,
    output logic               single_o
);
    // Capture the configuration at frame start; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_o  <= TOTAL_W'(TOTAL_RST);
            ratio2_o <= RATIO_W'(RATIO2_RST);
            ratio3_o <= RATIO_W'(RATIO3_RST);
            auto_o   <= AUTO_RST;
            single_o <= SINGLE_RST;
        end else if (capture_i) begin
            total_o  <= total_i;
            ratio2_o <= ratio2_i;
            ratio3_o <= ratio3_i;
            auto_o   <= auto_i;
            single_o <= single_i;
        end
    end
endmodule

// File: rtl/wdr_seg_calc.sv
// Module: derives the knee row positions from the held configuration.
// The second and third segment lengths are right shifts of the total. The
// first segment is the remainder, clamped to 1 row when the other two use up
// the total. Purely combinational; assumes its inputs are stable for the frame.
module wdr_seg_calc #(
    parameter int TOTAL_W = 15,
    parameter int RATIO_W = 4
) (
    input  logic [TOTAL_W-1:0] total_i,
    input  logic [RATIO_W-1:0] ratio2_i,
    input  logic [RATIO_W-1:0] ratio3_i,
    input  logic               auto_i,
    input  logic               single_i,
    output logic [TOTAL_W-1:0] k1_pos_o,
    output logic               k1_en_o,
    output logic [TOTAL_W:0]   k2_pos_o,
    output logic               k2_en_o
);
    localparam int SUM_W = TOTAL_W + 1;

    logic [TOTAL_W-1:0] seg2, seg3, seg1;
    logic [SUM_W-1:0]   tail_sum;
    logic               clamp;

    // Shift-based segment lengths, gated by the mode bits.
    always_comb begin
        seg2 = auto_i ? (total_i >> ratio2_i) : '0;
        seg3 = (auto_i && !single_i) ? (total_i >> ratio3_i) : '0;
    end

    // Remainder for the first segment, with the 1-row clamp.
    always_comb begin
        tail_sum = {1'b0, seg2} + {1'b0, seg3};
        clamp    = tail_sum >= {1'b0, total_i};
        seg1     = clamp ? TOTAL_W'(1) : (total_i - tail_sum[TOTAL_W-1:0]);
    end

    // Knee positions and enables; a zero-length segment drops its knee.
    always_comb begin
        k1_pos_o = seg1;
        k1_en_o  = seg2 != '0;
        k2_pos_o = {1'b0, seg1} + {1'b0, seg2};
        k2_en_o  = (seg3 != '0) && (k2_pos_o <= {1'b0, total_i});
    end
endmodule

// File: rtl/wdr_row_seq.sv
// Module: counts row ticks through one integration period and emits the
// one-cycle knee and done strobes. A start pulse restarts the count and
// overrides a tick in the same cycle. Assumes the positions stay stable
// while counting.
module wdr_row_seq #(
    parameter int TOTAL_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               tick_i,
    input  logic [TOTAL_W-1:0] total_i,
    input  logic [TOTAL_W-1:0] k1_pos_i,
    input  logic               k1_en_i,
    input  logic [TOTAL_W:0]   k2_pos_i,
    input  logic               k2_en_i,
    output logic               knee1_o,
    output logic               knee2_o,
    output logic               done_o,
    output logic               active_o
);
    logic [TOTAL_W-1:0] row_cnt;
    logic [TOTAL_W-1:0] cnt_nxt;

    // Count value after the current tick.
    always_comb cnt_nxt = row_cnt + TOTAL_W'(1);

    // Row counter, frame state and registered one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_cnt  <= '0;
            active_o <= 1'b0;
            knee1_o  <= 1'b0;
            knee2_o  <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            knee1_o <= 1'b0;
            knee2_o <= 1'b0;
            done_o  <= 1'b0;
            if (start_i) begin
                row_cnt  <= '0;
                active_o <= 1'b1;
            end else if (tick_i && active_o) begin
                row_cnt <= cnt_nxt;
                knee1_o <= k1_en_i && (cnt_nxt == k1_pos_i);
                knee2_o <= k2_en_i && ({1'b0, cnt_nxt} == k2_pos_i);
                if (cnt_nxt >= total_i) begin
                    done_o   <= 1'b1;
                    active_o <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/wdr_knee_sched.sv
// Module: top of the dual-knee exposure time scheduler.
// Holds the per-frame configuration, derives the knee positions and runs the
// row sequencer. Assumes row_tick_i and frame_start_i are one-cycle pulses
// synchronous to clk.
module wdr_knee_sched
    import wdr_knee_pkg::*;
#(
    parameter int TOTAL_W = TOTAL_W_DEF,
    parameter int RATIO_W = RATIO_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start_i,
    input  logic               row_tick_i,
    input  logic [TOTAL_W-1:0] cfg_total_i,
    input  logic [RATIO_W-1:0] cfg_ratio2_i,
    input  logic [RATIO_W-1:0] cfg_ratio3_i,
    input  logic               cfg_auto_i,
    input  logic               cfg_single_i,
    output logic               knee1_o,
    output logic               knee2_o,
    output logic               done_o,
    output logic               active_o
);
    logic [TOTAL_W-1:0] hold_total;
    logic [RATIO_W-1:0] hold_r2, hold_r3;
    logic               hold_auto, hold_single;
    logic [TOTAL_W-1:0] k1_pos;
    logic [TOTAL_W:0]   k2_pos;
    logic               k1_en, k2_en;

    wdr_cfg_hold #(.TOTAL_W(TOTAL_W), .RATIO_W(RATIO_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture_i(frame_start_i),
        .total_i  (cfg_total_i),
        .ratio2_i (cfg_ratio2_i),
        .ratio3_i (cfg_ratio3_i),
        .auto_i   (cfg_auto_i),
        .single_i (cfg_single_i),
        .total_o  (hold_total),
        .ratio2_o (hold_r2),
        .ratio3_o (hold_r3),
        .auto_o   (hold_auto),
        .single_o (hold_single)
    );

    wdr_seg_calc #(.TOTAL_W(TOTAL_W), .RATIO_W(RATIO_W)) u_calc (
        .total_i (hold_total),
        .ratio2_i(hold_r2),
        .ratio3_i(hold_r3),
        .auto_i  (hold_auto),
        .single_i(hold_single),
        .k1_pos_o(k1_pos),
        .k1_en_o (k1_en),
        .k2_pos_o(k2_pos),
        .k2_en_o (k2_en)
    );

    wdr_row_seq #(.TOTAL_W(TOTAL_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (frame_start_i),
        .tick_i  (row_tick_i),
        .total_i (hold_total),
        .k1_pos_i(k1_pos),
        .k1_en_i (k1_en),
        .k2_pos_i(k2_pos),
        .k2_en_i (k2_en),
        .knee1_o (knee1_o),
        .knee2_o (knee2_o),
        .done_o  (done_o),
        .active_o(active_o)
    );
endmodule

// File: rtl/wdr_knee_sched_chk.sv
// Module: protocol checker for the knee scheduler, attached by bind.
// Observes only the top-level ports.
module wdr_knee_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_start_i,
    input logic row_tick_i,
    input logic knee1_o,
    input logic knee2_o,
    input logic done_o,
    input logic active_o
);
    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (active_o && !knee1_o && !knee2_o && !done_o)); // R2

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !active_o); // R5

    AST_KNEES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(knee1_o && knee2_o)); // R4

    AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (knee1_o || knee2_o || done_o) |-> $past(row_tick_i && !frame_start_i && active_o)); // R12

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R12
endmodule

bind wdr_knee_sched wdr_knee_sched_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(frame_start_i),
    .row_tick_i   (row_tick_i),
    .knee1_o      (knee1_o),
    .knee2_o      (knee2_o),
    .done_o       (done_o),
    .active_o     (active_o)
);

// File: tb/wdr_knee_sched_bench.sv
// Bench: sweeps small totals against every small shift pair in all four
// modes, with the knee positions computed arithmetically here.
module wdr_knee_sched_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start_i = 1'b0;
    logic        row_tick_i = 1'b0;
    logic [14:0] cfg_total_i = '0;
    logic [3:0]  cfg_ratio2_i = '0;
    logic [3:0]  cfg_ratio3_i = '0;
    logic        cfg_auto_i = 1'b0;
    logic        cfg_single_i = 1'b0;
    logic        knee1_o, knee2_o, done_o, active_o;

    int total_checks = 0;
    int bad_checks = 0;

    always #2 clk = ~clk;

    wdr_knee_sched u_wdr_knee_sched (.*);

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        total_checks++;
        if (act != exp) begin
            bad_checks++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drives a frame and checks every tick against the positions computed here.
    task automatic run_frame(input int t, input int r2, input int r3,
                             input bit au, input bit si, input bit tick_at_start);
        int s2, s3, s1, k1, k2;
        bit e1, e2;
        string tag;
        s2 = au ? (t >> r2) : 0;
        s3 = (au && !si) ? (t >> r3) : 0;
        s1 = (s2 + s3 >= t) ? 1 : t - s2 - s3;
        k1 = s1;
        e1 = s2 != 0;
        k2 = s1 + s2;
        e2 = (s3 != 0) && (k2 <= t);
        if (!au)                    tag = "R7";
        else if (s2 + s3 >= t)      tag = "R9";
        else if (si)                tag = "R6";
        else if (s2 == 0 || s3 == 0) tag = "R8";
        else                        tag = "R3";
        @(negedge clk);
        cfg_total_i = 15'(t);
        cfg_ratio2_i = 4'(r2);
        cfg_ratio3_i = 4'(r3);
        cfg_auto_i = au;
        cfg_single_i = si;
        frame_start_i = 1'b1;
        row_tick_i = tick_at_start;
        @(posedge clk); #1;
        check(tick_at_start ? "R11" : "R2", "active after start", int'(active_o), 1);
        check(tick_at_start ? "R11" : "R2", "strobes after start",
              int'(knee1_o | knee2_o | done_o), 0);
        @(negedge clk);
        frame_start_i = 1'b0;
        // R10: scramble the configuration inputs for the rest of the frame
        cfg_total_i = 15'(t + 3);
        cfg_ratio2_i = 4'(r2 + 1);
        cfg_ratio3_i = 4'(r3 + 2);
        cfg_auto_i = !au;
        cfg_single_i = !si;
        for (int i = 1; i <= t; i++) begin
            row_tick_i = 1'b1;
            @(posedge clk); #1;
            check(tag, "knee1", int'(knee1_o), int'(e1 && i == k1));
            check(si ? "R6" : "R4", "knee2", int'(knee2_o), int'(e2 && i == k2));
            check("R5", "done", int'(done_o), int'(i == t));
            check("R10", "active", int'(active_o), int'(i != t));
            @(negedge clk);
        end
        row_tick_i = 1'b0;
        @(posedge clk); #1;
        check("R12", "strobes idle cycle", int'(knee1_o | knee2_o | done_o), 0);
        @(negedge clk);
        row_tick_i = 1'b1;
        @(posedge clk); #1;
        check("R5", "strobes after done", int'(knee1_o | knee2_o | done_o | active_o), 0);
        @(negedge clk);
        row_tick_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad_checks++;
        total_checks++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "outputs after reset",
              int'({knee1_o, knee2_o, done_o, active_o}), 0);
        row_tick_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "ticks before first frame",
              int'({knee1_o, knee2_o, done_o, active_o}), 0);
        @(negedge clk);
        row_tick_i = 1'b0;
        for (int t = 1; t <= 20; t++)
            for (int r2 = 0; r2 <= 4; r2++)
                for (int r3 = 0; r3 <= 4; r3++)
                    for (int m = 0; m < 4; m++)
                        run_frame(t, r2, r3, m[0], m[1], 1'b0);
        run_frame(480, 4, 6, 1'b1, 1'b0, 1'b0);
        run_frame(1000, 15, 9, 1'b1, 1'b0, 1'b0);
        run_frame(600, 3, 15, 1'b1, 1'b0, 1'b0);
        // R11: restart in the middle of a frame with a tick in the start cycle
        @(negedge clk);
        cfg_total_i = 15'd10;
        cfg_ratio2_i = 4'd1;
        cfg_ratio3_i = 4'd2;
        cfg_auto_i = 1'b1;
        cfg_single_i = 1'b0;
        frame_start_i = 1'b1;
        @(negedge clk);
        frame_start_i = 1'b0;
        row_tick_i = 1'b1;
        repeat (4) @(negedge clk);
        row_tick_i = 1'b0;
        run_frame(6, 1, 1, 1'b1, 1'b0, 1'b1);
        run_frame(5, 2, 1, 1'b1, 1'b1, 1'b1);
        $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end
endmodule